// File: doc/BRIEF.md
# Issue Queue Loop Replay Sequencer

This block sits beside an issue queue that already holds the instructions of a small loop, and feeds those instructions back to the rename stage so that fetch, decode and the dynamic branch predictor can stay idle. While the replay-enable input is high, a pointer walks the buffered region from its first to its last entry. Each cycle it looks at a window of `GRP` consecutive entries. When every entry in the window has its issued flag set, the block sends the entries' stored logical-register fields to rename and asks the queue to clear the issued flags of those same entries. The pointer then moves on, and after the last buffered entry it returns to the first.

Branches that are replayed get a static direction. The loop-closing branch, which is the entry at the last buffered index, is always predicted taken. Every other branch uses the direction recorded for it while the loop was being buffered. When the resolved outcome of a branch disagrees with that static direction, the block raises a one-cycle exit request so that the queue can fall back to normal operation. Replay then stays stopped until the enable input is dropped. An ordinary loop exit is reported in exactly this way, because it shows up as a not-taken outcome on the loop-closing branch.

All outputs are registered. A decision taken on the inputs sampled at clock edge t appears on the outputs right after edge t.

Top module: `iq_replay_seq`

## Requirements
- R1: While `rst` is high, at the next edge `req_valid`, `req_idx`, `req_regs`, `req_pred`, `clr_issued` and `exit_req` all become zero, and every recorded branch direction becomes not-taken (0).
- R2: While `reuse_en` is low, no request is sent and no exit is requested. In the first cycle after `reuse_en` rises, the window starts at `first_idx`.
- R3: When every entry in the window has its issued flag set, lane k carries index ptr+k and that entry's register field (`regs_flat[idx*RLW +: RLW]`), lane 0 holds the lowest index, and the pointer advances by `GRP`.
- R4: If any entry in the window has its issued flag clear, `req_valid` is zero for that cycle and the pointer holds.
- R5: A window that would run past `last_idx` is cut short at `last_idx`. Only a contiguous set of lanes starting at lane 0 is valid, and the next window starts at `first_idx`.
- R6: A full window whose final lane lands exactly on `last_idx` is followed by a window at `first_idx`.
- R7: `clr_issued` has bit i set in exactly the cycle that entry i is presented on a valid lane, and has no other bits set.
- R8: `req_pred` for a lane is 1 when its index equals `last_idx`. Otherwise it is the direction last written through the capture port (`cap_we`, `cap_idx`, `cap_taken`, where 1 means taken).
- R9: A resolved branch (`res_valid`) whose `res_taken` differs from its static direction, while replay is running, raises `exit_req` for exactly one cycle. Replay then stays stopped until `reuse_en` goes low. Resolutions that arrive while `reuse_en` is low are ignored.
- R10: A resolved branch that matches its static direction does not raise `exit_req`, and replay continues.
- R11: In the cycle a mismatch is detected, no request is sent, even if the window is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reuse_en | input | 1 | Replay mode active |
| issued | input | DEPTH | Per-entry issued flags |
| regs_flat | input | DEPTH*RLW | Stored logical-register field of each entry |
| first_idx | input | IDXW | First buffered entry |
| last_idx | input | IDXW | Last buffered entry (first_idx <= last_idx) |
| cap_we | input | 1 | Record a branch direction seen while buffering |
| cap_idx | input | IDXW | Entry whose direction is recorded |
| cap_taken | input | 1 | Recorded direction, 1 = taken |
| res_valid | input | 1 | A replayed branch has resolved |
| res_idx | input | IDXW | Entry of the resolved branch |
| res_taken | input | 1 | Resolved direction, 1 = taken |
| req_valid | output | GRP | Lane valid mask for rename |
| req_idx | output | GRP*IDXW | Entry index per lane |
| req_regs | output | GRP*RLW | Register field per lane |
| req_pred | output | GRP | Static direction per lane |
| clr_issued | output | DEPTH | Issued-flag clear strobe per entry |
| exit_req | output | 1 | Leave replay mode (static mispredict) |

## Verification
The assertions check on every cycle the properties that can be seen locally. While replay is disabled, the block stays silent. A stalled window produces no lanes. Valid lanes always form a prefix starting at lane 0. The number of bits in the clear strobe always equals the number of valid lanes. An exit request lasts one cycle and never comes together with a request. Only the bench's scenarios can show where the pointer goes over several cycles: the truncation and wrap back to the first entry, the exact-end wrap, the reload when replay is re-entered, and the hold on a stall. The bench also covers which static direction each lane carries after the capture port writes, and the halted state that follows a mispredict.

// File: rtl/iqr_pkg.sv
package iqr_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_RUN  = 2'd1,
    RS_HALT = 2'd2
  } rs_state_e;
endpackage

// File: rtl/iqr_window.sv
// Combinational view of the GRP-wide replay window starting at cur_ptr.
module iqr_window #(
  parameter int DEPTH = 16,
  parameter int GRP   = 4,
  parameter int IDXW  = 4,
  parameter int RLW   = 8
) (
  input  logic [IDXW-1:0]      cur_ptr,
  input  logic [IDXW-1:0]      last_idx,
  input  logic [DEPTH-1:0]     issued,
  input  logic [DEPTH*RLW-1:0] regs_flat,
  output logic [GRP-1:0]       lane_act,
  output logic [GRP*IDXW-1:0]  lane_idx,
  output logic [GRP*RLW-1:0]   lane_regs,
  output logic                 all_ready,
  output logic                 wrap
);
  localparam int CW   = IDXW + 1;
  localparam int SPAN = 2 ** IDXW;

  logic [SPAN-1:0]     iss_pad;
  logic [SPAN*RLW-1:0] regs_pad;
  logic [GRP-1:0]      lane_rdy;

  assign iss_pad  = SPAN'(issued);
  assign regs_pad = (SPAN*RLW)'(regs_flat);

  for (genvar k = 0; k < GRP; k++) begin : g_lane
    logic [CW-1:0]   pos;
    logic [IDXW-1:0] idx;
    assign pos         = {1'b0, cur_ptr} + CW'(k);
    assign lane_act[k] = (pos <= {1'b0, last_idx});
    assign idx         = lane_act[k] ? pos[IDXW-1:0] : '0;
    assign lane_idx[k*IDXW +: IDXW] = idx;
    assign lane_regs[k*RLW +: RLW]  = lane_act[k] ? regs_pad[idx*RLW +: RLW] : '0;
    assign lane_rdy[k]  = !lane_act[k] || iss_pad[idx];
  end

  assign all_ready = &lane_rdy;
  assign wrap      = ({1'b0, cur_ptr} + CW'(GRP)) > {1'b0, last_idx};
endmodule

// File: rtl/iqr_dir_table.sv
// Per-entry branch direction recorded while buffering; static lookup during replay.
module iqr_dir_table #(
  parameter int DEPTH = 16,
  parameter int GRP   = 4,
  parameter int IDXW  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_we,
  input  logic [IDXW-1:0]     cap_idx,
  input  logic                cap_taken,
  input  logic [IDXW-1:0]     last_idx,
  input  logic [GRP*IDXW-1:0] lane_idx,
  input  logic [IDXW-1:0]     res_idx,
  output logic [GRP-1:0]      lane_pred,
  output logic                res_pred
);
  localparam int SPAN = 2 ** IDXW;

  logic [DEPTH-1:0] dir_q;
  logic [SPAN-1:0]  dir_pad;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else if (cap_we && (32'(cap_idx) < DEPTH)) begin
      dir_q[cap_idx] <= cap_taken;
    end
  end

  assign dir_pad = SPAN'(dir_q);

  for (genvar k = 0; k < GRP; k++) begin : g_pred
    logic [IDXW-1:0] li;
    assign li           = lane_idx[k*IDXW +: IDXW];
    assign lane_pred[k] = (li == last_idx) ? 1'b1 : dir_pad[li];
  end

  assign res_pred = (res_idx == last_idx) ? 1'b1 : dir_pad[res_idx];
endmodule

// File: rtl/iq_replay_seq.sv
module iq_replay_seq
  import iqr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int GRP   = 4,
  parameter int RLW   = 8,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reuse_en,
  input  logic [DEPTH-1:0]     issued,
  input  logic [DEPTH*RLW-1:0] regs_flat,
  input  logic [IDXW-1:0]      first_idx,
  input  logic [IDXW-1:0]      last_idx,
  input  logic                 cap_we,
  input  logic [IDXW-1:0]      cap_idx,
  input  logic                 cap_taken,
  input  logic                 res_valid,
  input  logic [IDXW-1:0]      res_idx,
  input  logic                 res_taken,
  output logic [GRP-1:0]       req_valid,
  output logic [GRP*IDXW-1:0]  req_idx,
  output logic [GRP*RLW-1:0]   req_regs,
  output logic [GRP-1:0]       req_pred,
  output logic [DEPTH-1:0]     clr_issued,
  output logic                 exit_req
);
  rs_state_e       state_q;
  logic [IDXW-1:0] ptr_q, cur_ptr, next_ptr;
  logic [GRP-1:0]      lane_act, lane_pred;
  logic [GRP*IDXW-1:0] lane_idx;
  logic [GRP*RLW-1:0]  lane_regs;
  logic all_ready, wrap, res_pred, active, mispred, fire;
  logic [DEPTH-1:0] clr_mask;

  // In IDLE the window always starts at the first buffered entry.
  assign cur_ptr = (state_q == RS_IDLE) ? first_idx : ptr_q;

  iqr_window #(.DEPTH(DEPTH), .GRP(GRP), .IDXW(IDXW), .RLW(RLW)) u_window (
    .cur_ptr   (cur_ptr),
    .last_idx  (last_idx),
    .issued    (issued),
    .regs_flat (regs_flat),
    .lane_act  (lane_act),
    .lane_idx  (lane_idx),
    .lane_regs (lane_regs),
    .all_ready (all_ready),
    .wrap      (wrap)
  );

  iqr_dir_table #(.DEPTH(DEPTH), .GRP(GRP), .IDXW(IDXW)) u_dir (
    .clk       (clk),
    .rst       (rst),
    .cap_we    (cap_we),
    .cap_idx   (cap_idx),
    .cap_taken (cap_taken),
    .last_idx  (last_idx),
    .lane_idx  (lane_idx),
    .res_idx   (res_idx),
    .lane_pred (lane_pred),
    .res_pred  (res_pred)
  );

  assign active   = reuse_en && (state_q != RS_HALT);
  assign mispred  = active && res_valid && (res_taken != res_pred);
  assign fire     = active && !mispred && all_ready;
  assign next_ptr = wrap ? first_idx : (cur_ptr + IDXW'(GRP));

  always_comb begin
    clr_mask = '0;
    for (int k = 0; k < GRP; k++) begin
      if (lane_act[k] && (32'(lane_idx[k*IDXW +: IDXW]) < DEPTH)) begin
        clr_mask[lane_idx[k*IDXW +: IDXW]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= RS_IDLE;
      ptr_q      <= '0;
      req_valid  <= '0;
      req_idx    <= '0;
      req_regs   <= '0;
      req_pred   <= '0;
      clr_issued <= '0;
      exit_req   <= 1'b0;
    end else begin
      if (!reuse_en)               state_q <= RS_IDLE;
      else if (mispred)            state_q <= RS_HALT;
      else if (state_q == RS_IDLE) state_q <= RS_RUN;

      if (!reuse_en) ptr_q <= first_idx;
      else if (fire) ptr_q <= next_ptr;
      else           ptr_q <= cur_ptr;

      req_valid  <= fire ? lane_act  : '0;
      req_idx    <= fire ? lane_idx  : '0;
      req_regs   <= fire ? lane_regs : '0;
      req_pred   <= fire ? (lane_pred & lane_act) : '0;
      clr_issued <= fire ? clr_mask  : '0;
      exit_req   <= mispred;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !reuse_en |=> (req_valid == '0 && !exit_req)); // R2
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (active && !all_ready) |=> (req_valid == '0)); // R4
  AST_LANE_PREFIX: assert property (@(posedge clk) disable iff (rst)
    ((req_valid & (req_valid + GRP'(1))) == '0)); // R5
  AST_CLR_COUNT: assert property (@(posedge clk) disable iff (rst)
    ($countones(clr_issued) == $countones(req_valid))); // R7
  AST_EXIT_PULSE: assert property (@(posedge clk) disable iff (rst)
    exit_req |=> !exit_req); // R9
  AST_EXIT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    exit_req |-> (req_valid == '0)); // R11
endmodule

// File: tb/test_iq_replay_seq.sv
`timescale 1ns/1ps
module test_iq_replay_seq;
  localparam int DEPTH = 16;
  localparam int GRP   = 4;
  localparam int RLW   = 8;
  localparam int IDXW  = 4;
  localparam int NV    = 16;

  logic clk = 1'b0;
  logic rst, reuse_en, cap_we, cap_taken, res_valid, res_taken;
  logic [DEPTH-1:0]     issued;
  logic [DEPTH*RLW-1:0] regs_flat;
  logic [IDXW-1:0]      first_idx, last_idx, cap_idx, res_idx;
  logic [GRP-1:0]       req_valid, req_pred;
  logic [GRP*IDXW-1:0]  req_idx;
  logic [GRP*RLW-1:0]   req_regs;
  logic [DEPTH-1:0]     clr_issued;
  logic                 exit_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  iq_replay_seq #(.DEPTH(DEPTH), .GRP(GRP), .RLW(RLW)) i_iq_replay_seq (
    .clk(clk), .rst(rst), .reuse_en(reuse_en), .issued(issued),
    .regs_flat(regs_flat), .first_idx(first_idx), .last_idx(last_idx),
    .cap_we(cap_we), .cap_idx(cap_idx), .cap_taken(cap_taken),
    .res_valid(res_valid), .res_idx(res_idx), .res_taken(res_taken),
    .req_valid(req_valid), .req_idx(req_idx), .req_regs(req_regs),
    .req_pred(req_pred), .clr_issued(clr_issued), .exit_req(exit_req)
  );

  // en | issued | first | last | rv | ri | rt || exp_valid | exp_idx0 | exp_exit
  localparam logic [39:0] VEC [NV] = '{
    {1'b0,16'hFFFF,4'd2,4'd12,1'b0,4'd0 ,1'b0, 4'b0000,4'd0 ,1'b0}, // R2 idle
    {1'b1,16'hFFFF,4'd2,4'd12,1'b0,4'd0 ,1'b0, 4'b1111,4'd2 ,1'b0}, // R2 R3 entry
    {1'b1,16'hFFFF,4'd2,4'd12,1'b0,4'd0 ,1'b0, 4'b1111,4'd6 ,1'b0}, // R3 advance
    {1'b1,16'hF7FF,4'd2,4'd12,1'b0,4'd0 ,1'b0, 4'b0000,4'd0 ,1'b0}, // R4 stall
    {1'b1,16'hFFFF,4'd2,4'd12,1'b0,4'd0 ,1'b0, 4'b0111,4'd10,1'b0}, // R4 hold, R5 cut
    {1'b1,16'hFFFF,4'd2,4'd12,1'b0,4'd0 ,1'b0, 4'b1111,4'd2 ,1'b0}, // R5 wrap
    {1'b1,16'hFFFF,4'd2,4'd12,1'b1,4'd5 ,1'b1, 4'b1111,4'd6 ,1'b0}, // R10 match
    {1'b1,16'hFFFF,4'd2,4'd12,1'b1,4'd12,1'b1, 4'b0111,4'd10,1'b0}, // R10 loop branch
    {1'b1,16'hFFFF,4'd2,4'd12,1'b1,4'd3 ,1'b1, 4'b0000,4'd0 ,1'b1}, // R9 R11 mismatch
    {1'b1,16'hFFFF,4'd2,4'd12,1'b0,4'd0 ,1'b0, 4'b0000,4'd0 ,1'b0}, // R9 halted
    {1'b0,16'hFFFF,4'd4,4'd11,1'b0,4'd0 ,1'b0, 4'b0000,4'd0 ,1'b0}, // R2 leave
    {1'b1,16'hFFFF,4'd4,4'd11,1'b0,4'd0 ,1'b0, 4'b1111,4'd4 ,1'b0}, // R2 reload
    {1'b1,16'hFFFF,4'd4,4'd11,1'b0,4'd0 ,1'b0, 4'b1111,4'd8 ,1'b0}, // R6 exact end
    {1'b1,16'hFFFF,4'd4,4'd11,1'b0,4'd0 ,1'b0, 4'b1111,4'd4 ,1'b0}, // R6 wrap
    {1'b1,16'hFFFF,4'd4,4'd11,1'b1,4'd11,1'b0, 4'b0000,4'd0 ,1'b1}, // R9 loop exit
    {1'b0,16'hFFFF,4'd4,4'd11,1'b1,4'd3 ,1'b1, 4'b0000,4'd0 ,1'b0}  // R9 ignored
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Checks every lane of the current output against a window of count lanes at idx0.
  task automatic chk_lanes(input string tag, input logic [GRP-1:0] ev,
                           input logic [IDXW-1:0] idx0, input logic [IDXW-1:0] lst,
                           input logic [DEPTH-1:0] dirs);
    logic [DEPTH-1:0] exp_clr = '0;
    for (int k = 0; k < GRP; k++) begin
      if (ev[k]) begin
        logic [IDXW-1:0] ix = idx0 + IDXW'(k);
        exp_clr[ix] = 1'b1;
        chk({tag, " R3 idx"}, 64'(req_idx[k*IDXW +: IDXW]), 64'(ix));
        chk({tag, " R3 regs"}, 64'(req_regs[k*RLW +: RLW]), 64'(8'hA0 + 8'(ix)));
        chk({tag, " R8 pred"}, 64'(req_pred[k]), 64'((ix == lst) ? 1'b1 : dirs[ix]));
      end
    end
    chk({tag, " R7 clr"}, 64'(clr_issued), 64'(exp_clr));
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) regs_flat[i*RLW +: RLW] = 8'hA0 + 8'(i);
    rst = 1'b1; reuse_en = 1'b1; issued = '1; first_idx = 4'd2; last_idx = 4'd12;
    cap_we = 1'b0; cap_idx = '0; cap_taken = 1'b0;
    res_valid = 1'b0; res_idx = '0; res_taken = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid", 64'(req_valid), 64'(0));
    chk("R1 clr", 64'(clr_issued), 64'(0));
    chk("R1 exit", 64'(exit_req), 64'(0));
    chk("R1 regs", 64'(req_regs), 64'(0));
    @(negedge clk);
    rst = 1'b0; reuse_en = 1'b0;
    cap_we = 1'b1; cap_idx = 4'd5; cap_taken = 1'b1;
    @(negedge clk);
    cap_we = 1'b0;

    for (int v = 0; v < NV; v++) begin
      logic [39:0] w = VEC[v];
      reuse_en = w[39]; issued = w[38:23]; first_idx = w[22:19]; last_idx = w[18:15];
      res_valid = w[14]; res_idx = w[13:10]; res_taken = w[9];
      @(posedge clk);
      #1;
      chk($sformatf("vec%0d R3 R4 R5 valid", v), 64'(req_valid), 64'(w[8:5]));
      chk($sformatf("vec%0d R9 R10 R11 exit", v), 64'(exit_req), 64'(w[0]));
      chk_lanes($sformatf("vec%0d", v), w[8:5], w[4:1], w[18:15], 16'h0020);
      @(negedge clk);
    end

    // R8: overwrite a recorded direction, then a matching not-taken result must not exit.
    reuse_en = 1'b0; res_valid = 1'b0;
    cap_we = 1'b1; cap_idx = 4'd5; cap_taken = 1'b0;
    @(negedge clk);
    cap_we = 1'b0;
    reuse_en = 1'b1; issued = '1; first_idx = 4'd2; last_idx = 4'd12;
    res_valid = 1'b1; res_idx = 4'd5; res_taken = 1'b0;
    @(posedge clk);
    #1;
    chk("R8 R10 recaptured exit", 64'(exit_req), 64'(0));
    chk("R8 recaptured valid", 64'(req_valid), 64'(4'b1111));
    chk_lanes("R8 recaptured", 4'b1111, 4'd2, 4'd12, 16'h0000);
    @(negedge clk);
    res_valid = 1'b0; reuse_en = 1'b0;

    // R1: reset in the middle of replay clears outputs.
    reuse_en = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 mid valid", 64'(req_valid), 64'(0));
    chk("R1 mid clr", 64'(clr_issued), 64'(0));
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 R2 restart idx0", 64'(req_idx[IDXW-1:0]), 64'(4'd2));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule